// File: doc/BRIEF.md
# Multi-Mode Program Bank Mapper

This block sits between a CPU with a 16-bit address bus and an external program ROM plus a battery-backed work RAM. It maps the top 32 KB of the CPU address space onto the program ROM and the 8 KB window at 0x6000–0x7FFF onto the work RAM. The ROM is divided into 8 KB pages, and the 32 KB window can be arranged as one 32 KB bank, two 16 KB banks, one 16 KB bank followed by two 8 KB banks, or four independent 8 KB banks. A single set of bank registers serves all four arrangements. How many bits of each register form the page number depends on the size of the window that register drives.

The CPU programs the block through a write port that carries the register address and data. The translation path is purely combinational from `cpu_addr`, so a lookup costs no clock cycles. A register write takes effect on the clock edge that accepts it. The installed ROM size is given as a power of two on `rom_size_log2`. Page numbers that point beyond the installed ROM wrap by dropping the upper address bits.

Top module: `prg_bank_mapper`

## Requirements
- R1: A write with `wr_en` high to address 0x5100 loads the banking mode from `wr_data[1:0]`, effective from the next clock edge; data bits [7:2] are ignored. Mode codes: 0 = one 32 KB bank, 1 = two 16 KB banks, 2 = 16 KB + 8 KB + 8 KB, 3 = four 8 KB banks.
- R2: Writes to 0x5113 + n (n = 0..4) load bank register n. Register 0 keeps only data bits [2:0]. Registers 1–4 keep data bits [6:0], and bit 7 has no effect on translation.
- R3: For `cpu_addr` in 0x6000–0x7FFF, `ram_addr` equals register 0 × 8192 + (`cpu_addr` − 0x6000).
- R4: In mode 0, the ROM offset for `cpu_addr` A in 0x8000–0xFFFF is (register 4 bits [6:2]) × 32768 + (A − 0x8000).
- R5: In mode 1, 0x8000–0xBFFF maps to (register 2 bits [6:1]) × 16384 + (A − 0x8000), and 0xC000–0xFFFF maps to (register 4 bits [6:1]) × 16384 + (A − 0xC000).
- R6: In mode 2, 0x8000–0xBFFF maps as in R5 through register 2. 0xC000–0xDFFF maps to (register 3 bits [6:0]) × 8192 + (A − 0xC000), and 0xE000–0xFFFF maps to (register 4 bits [6:0]) × 8192 + (A − 0xE000).
- R7: In mode 3, the 8 KB slot s = `cpu_addr[14:13]` maps to (register s+1 bits [6:0]) × 8192 + `cpu_addr[12:0]`.
- R8: `rom_addr` is the offset from R4–R7 taken modulo 8192 × 2^`rom_size_log2`, for `rom_size_log2` from 0 to 7.
- R9: While `rst_n` is low at a clock edge, the mode becomes 3, register 0 becomes 0, and register n (n = 1..4) becomes (2^`rom_size_log2` − 5 + n) mod 128, which are the last four 8 KB pages of the ROM.
- R10: `win_sel` is 2'b10 for `cpu_addr` 0x8000–0xFFFF, 2'b01 for 0x6000–0x7FFF, and 2'b00 elsewhere.
- R11: Writes with `wr_en` low, and writes to any address other than 0x5100 and 0x5113–0x5117, leave every translation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rom_size_log2 | input | 3 | Installed ROM size as log2 of the number of 8 KB pages |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| cpu_addr | input | 16 | CPU address to translate |
| rom_addr | output | 20 | Physical program ROM byte address |
| ram_addr | output | 16 | Physical work RAM byte address |
| win_sel | output | 2 | Window hit: 2'b10 ROM, 2'b01 RAM, 2'b00 none |

## Verification
Every mode is swept over all four 8 KB slots, at the first byte, the second byte, a mid-slot byte and the last byte of each slot. This separates the page bits taken from each register from the bits that pass through from the CPU address. The register patterns have bit 7 and the low register bits set in different combinations, so a wrong bit slice (for example [6:1] where [6:2] belongs) gives a different page. The sweeps repeat at several ROM sizes, including the smallest useful size, where most page bits must wrap away. Writes to neighbouring addresses, writes with the strobe low, and resets at two ROM sizes confirm that only decoded writes change the mapping and that the reset pages follow the configured size.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

   typedef enum logic [1:0] {
      PBM_MODE_32K     = 2'd0,
      PBM_MODE_16K16K  = 2'd1,
      PBM_MODE_16K8K8K = 2'd2,
      PBM_MODE_8KX4    = 2'd3
   } pbm_mode_e;

   typedef enum logic [1:0] {
      PBM_SEL_NONE = 2'b00,
      PBM_SEL_RAM  = 2'b01,
      PBM_SEL_ROM  = 2'b10
   } pbm_sel_e;

   localparam int PBM_NUM_ROM_REGS = 4;

endpackage

// File: rtl/pbm_regs.sv
module pbm_regs
   import pbm_pkg::*;
#(
   parameter int BANK_W     = 7,
   parameter int RAM_BANK_W = 3,
   parameter int DATA_W     = 8,
   parameter int CPU_AW     = 16,
   parameter int SZ_W       = 3,
   parameter int MODE_ADDR  = 'h5100,
   parameter int BANK_BASE  = 'h5113
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic [SZ_W-1:0]                              size_log2,
   input  logic                                         wr_en,
   input  logic [CPU_AW-1:0]                            wr_addr,
   input  logic [DATA_W-1:0]                            wr_data,
   output pbm_mode_e                                    mode_q,
   output logic [RAM_BANK_W-1:0]                        ram_bank_q,
   output logic [PBM_NUM_ROM_REGS-1:0][BANK_W-1:0]      bank_q
);

   localparam logic [CPU_AW-1:0] MODE_A = CPU_AW'(MODE_ADDR);
   localparam logic [CPU_AW-1:0] RAM_A  = CPU_AW'(BANK_BASE);

   logic                              mode_hit;
   logic                              ram_hit;
   logic [PBM_NUM_ROM_REGS-1:0]       bank_hit;
   logic                              any_hit;
   logic [BANK_W:0]                   page_count;
   logic [BANK_W-1:0]                 rst_val [PBM_NUM_ROM_REGS];

   assign mode_hit   = wr_en && (wr_addr == MODE_A);
   assign ram_hit    = wr_en && (wr_addr == RAM_A);
   assign page_count = (BANK_W+1)'(1) << size_log2;

   for (genvar i = 0; i < PBM_NUM_ROM_REGS; i++) begin : g_dec
      localparam logic [CPU_AW-1:0] REG_A = CPU_AW'(BANK_BASE + 1 + i);
      assign bank_hit[i] = wr_en && (wr_addr == REG_A);
      // reset page: last four pages of the ROM, in slot order
      assign rst_val[i]  = BANK_W'(page_count + (BANK_W+1)'(i)
                                  - (BANK_W+1)'(PBM_NUM_ROM_REGS));
   end

   assign any_hit = mode_hit | ram_hit | (|bank_hit);

   if (DATA_W > BANK_W) begin : g_hi
      logic unused_data_hi;
      assign unused_data_hi = ^wr_data[DATA_W-1:BANK_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q     <= PBM_MODE_8KX4;
         ram_bank_q <= '0;
         for (int i = 0; i < PBM_NUM_ROM_REGS; i++) begin
            bank_q[i] <= rst_val[i];
         end
      end else begin
         if (mode_hit) begin
            mode_q <= pbm_mode_e'(wr_data[1:0]);
         end
         if (ram_hit) begin
            ram_bank_q <= wr_data[RAM_BANK_W-1:0];
         end
         for (int i = 0; i < PBM_NUM_ROM_REGS; i++) begin
            if (bank_hit[i]) begin
               bank_q[i] <= wr_data[BANK_W-1:0];
            end
         end
      end
   end

   // R1: mode write lands on the next edge
   p_mode_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == MODE_A) |=> (mode_q == pbm_mode_e'($past(wr_data[1:0]))));

   // R2: bank register write lands on the next edge
   for (genvar i = 0; i < PBM_NUM_ROM_REGS; i++) begin : g_chk
      p_bank_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == CPU_AW'(BANK_BASE + 1 + i))
            |=> (bank_q[i] == $past(wr_data[BANK_W-1:0])));
   end

   // R11: no decoded write, no state change
   p_ignore_other_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !any_hit |=> ($stable(mode_q) && $stable(ram_bank_q) && $stable(bank_q)));

   // R9: leaving reset in four-slot mode
   p_reset_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mode_q == PBM_MODE_8KX4 && ram_bank_q == '0));

endmodule

// File: rtl/pbm_page_sel.sv
module pbm_page_sel
   import pbm_pkg::*;
#(
   parameter int BANK_W = 7
) (
   input  pbm_mode_e                                mode,
   input  logic [PBM_NUM_ROM_REGS-1:0][BANK_W-1:0]  bank_q,
   input  logic [1:0]                               slot,
   output logic [BANK_W-1:0]                        page
);

   logic [BANK_W-1:0] cand [PBM_NUM_ROM_REGS];

   for (genvar s = 0; s < PBM_NUM_ROM_REGS; s++) begin : g_slot
      localparam logic [1:0] SIDX   = 2'(s);
      localparam int         HALF_R = (s < 2) ? 1 : 3;   // 16 KB owner
      localparam int         MIX_R  = (s < 2) ? 1 : s;   // mode 2 owner
      logic [BANK_W-1:0] pg;

      always_comb begin
         unique case (mode)
            PBM_MODE_32K:
               pg = {bank_q[3][BANK_W-1:2], SIDX};
            PBM_MODE_16K16K:
               pg = {bank_q[HALF_R][BANK_W-1:1], SIDX[0]};
            PBM_MODE_16K8K8K:
               if (s < 2) pg = {bank_q[MIX_R][BANK_W-1:1], SIDX[0]};
               else       pg = bank_q[MIX_R];
            default:
               pg = bank_q[s];
         endcase
      end

      assign cand[s] = pg;
   end

   assign page = cand[slot];

endmodule

// File: rtl/pbm_wrap.sv
module pbm_wrap #(
   parameter int AW     = 20,
   parameter int SLOT_W = 13,
   parameter int SZ_W   = 3
) (
   input  logic [AW-1:0]   raw,
   input  logic [SZ_W-1:0] size_log2,
   output logic [AW-1:0]   wrapped
);

   logic [AW-1:0] keep;

   for (genvar b = 0; b < AW; b++) begin : g_bit
      assign keep[b] = (32'(size_log2) + 32'(SLOT_W)) > 32'(b);
   end

   assign wrapped = raw & keep;

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
   import pbm_pkg::*;
#(
   parameter int BANK_W     = 7,
   parameter int RAM_BANK_W = 3,
   parameter int SLOT_W     = 13,
   parameter int DATA_W     = 8,
   parameter int MODE_ADDR  = 'h5100,
   parameter int BANK_BASE  = 'h5113,
   localparam int CPU_AW    = SLOT_W + 3,
   localparam int ROM_AW    = BANK_W + SLOT_W,
   localparam int RAM_AW    = RAM_BANK_W + SLOT_W,
   localparam int SZ_W      = $clog2(BANK_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SZ_W-1:0]   rom_size_log2,
   input  logic              wr_en,
   input  logic [CPU_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CPU_AW-1:0] cpu_addr,
   output logic [ROM_AW-1:0] rom_addr,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [1:0]        win_sel
);

   if (BANK_W < 3 || BANK_W > DATA_W) begin : g_bad_bank
      $error("BANK_W must lie between 3 and DATA_W");
   end
   if (RAM_BANK_W < 1 || RAM_BANK_W > DATA_W) begin : g_bad_ram
      $error("RAM_BANK_W must lie between 1 and DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must hold the two mode bits");
   end

   pbm_mode_e                                  mode_q;
   logic [RAM_BANK_W-1:0]                      ram_bank_q;
   logic [PBM_NUM_ROM_REGS-1:0][BANK_W-1:0]    bank_q;
   logic [BANK_W-1:0]                          page;
   logic [ROM_AW-1:0]                          rom_raw;
   pbm_sel_e                                   sel;

   pbm_regs #(
      .BANK_W     (BANK_W),
      .RAM_BANK_W (RAM_BANK_W),
      .DATA_W     (DATA_W),
      .CPU_AW     (CPU_AW),
      .SZ_W       (SZ_W),
      .MODE_ADDR  (MODE_ADDR),
      .BANK_BASE  (BANK_BASE)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .size_log2  (rom_size_log2),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .mode_q     (mode_q),
      .ram_bank_q (ram_bank_q),
      .bank_q     (bank_q)
   );

   pbm_page_sel #(
      .BANK_W (BANK_W)
   ) u_page (
      .mode   (mode_q),
      .bank_q (bank_q),
      .slot   (cpu_addr[SLOT_W+1:SLOT_W]),
      .page   (page)
   );

   assign rom_raw = {page, cpu_addr[SLOT_W-1:0]};

   pbm_wrap #(
      .AW        (ROM_AW),
      .SLOT_W    (SLOT_W),
      .SZ_W      (SZ_W)
   ) u_wrap (
      .raw       (rom_raw),
      .size_log2 (rom_size_log2),
      .wrapped   (rom_addr)
   );

   assign ram_addr = {ram_bank_q, cpu_addr[SLOT_W-1:0]};

   always_comb begin
      if (cpu_addr[CPU_AW-1])
         sel = PBM_SEL_ROM;
      else if (cpu_addr[CPU_AW-2:CPU_AW-3] == 2'b11)
         sel = PBM_SEL_RAM;
      else
         sel = PBM_SEL_NONE;
   end

   assign win_sel = sel;

   // R8: a ROM address never reaches past the installed size
   p_rom_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (win_sel == PBM_SEL_ROM) |-> ((rom_addr >> (32'(SLOT_W) + 32'(rom_size_log2))) == '0));

   // R7: in four-slot mode the byte offset passes straight through
   p_slot_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (win_sel == PBM_SEL_ROM) |-> (rom_addr[SLOT_W-1:0] == cpu_addr[SLOT_W-1:0]));

endmodule

// File: tb/prg_bank_mapper_tb.sv
`timescale 1ns/1ps
module prg_bank_mapper_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  rom_size_log2 = 3'd5;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [15:0] cpu_addr = '0;
   logic [19:0] rom_addr;
   logic [15:0] ram_addr;
   logic [1:0]  win_sel;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   int m_mode;
   int m_k;
   int m_r [5];

   always #10 clk = ~clk;

   prg_bank_mapper u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .rom_size_log2 (rom_size_log2),
      .wr_en         (wr_en),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .cpu_addr      (cpu_addr),
      .rom_addr      (rom_addr),
      .ram_addr      (ram_addr),
      .win_sel       (win_sel)
   );

   function automatic int exp_rom(int a);
      int inner = a & 'h7FFF;
      int off;
      case (m_mode)
         0: off = ((m_r[4] >> 2) & 31) * 32768 + inner;
         1: if (inner < 'h4000) off = ((m_r[2] >> 1) & 63) * 16384 + inner;
            else                off = ((m_r[4] >> 1) & 63) * 16384 + inner - 'h4000;
         2: if (inner < 'h4000)      off = ((m_r[2] >> 1) & 63) * 16384 + inner;
            else if (inner < 'h6000) off = (m_r[3] & 127) * 8192 + inner - 'h4000;
            else                     off = (m_r[4] & 127) * 8192 + inner - 'h6000;
         default: off = (m_r[inner / 8192 + 1] & 127) * 8192 + inner % 8192;
      endcase
      return off % (8192 << m_k);
   endfunction

   task automatic do_reset(int k);
      @(negedge clk);
      rst_n = 1'b0;
      rom_size_log2 = 3'(k);
      m_k = k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_mode = 3;
      m_r[0] = 0;
      for (int i = 1; i < 5; i++) m_r[i] = ((1 << k) - 5 + i) & 127;
   endtask

   task automatic do_wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = 16'(a);
      wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
      if (a == 'h5100) m_mode = d & 3;
      else if (a == 'h5113) m_r[0] = d & 7;
      else if (a >= 'h5114 && a <= 'h5117) m_r[a - 'h5113] = d & 127;
   endtask

   task automatic chk_rom(int a, string req);
      int e;
      cpu_addr = 16'(a);
      #1;
      e = exp_rom(a);
      vectors++;
      if (rom_addr !== 20'(e) || win_sel !== 2'b10) begin
         miscompares++;
         $display("FAIL %s addr=%h mode=%0d k=%0d actual rom=%h sel=%b expected rom=%h sel=10",
                  req, a, m_mode, m_k, rom_addr, win_sel, e);
      end
   endtask

   task automatic chk_ram(int a, string req);
      int e;
      cpu_addr = 16'(a);
      #1;
      e = m_r[0] * 8192 + (a - 'h6000);
      vectors++;
      if (ram_addr !== 16'(e) || win_sel !== 2'b01) begin
         miscompares++;
         $display("FAIL %s addr=%h actual ram=%h sel=%b expected ram=%h sel=01",
                  req, a, ram_addr, win_sel, e);
      end
   endtask

   task automatic chk_sel(int a, int e, string req);
      cpu_addr = 16'(a);
      #1;
      vectors++;
      if (win_sel !== 2'(e)) begin
         miscompares++;
         $display("FAIL %s addr=%h actual sel=%b expected sel=%b", req, a, win_sel, 2'(e));
      end
   endtask

   task automatic sweep_rom(string req);
      int offs [4] = '{0, 1, 'h0ABC, 'h1FFF};
      for (int s = 0; s < 4; s++) begin
         for (int o = 0; o < 4; o++) begin
            chk_rom('h8000 + s * 8192 + offs[o], req);
         end
      end
   endtask

   initial begin
      #(20ns * 150000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      string mreq [4] = '{"R4", "R5", "R6", "R7"};

      // R9: reset state at two ROM sizes
      do_reset(5);
      sweep_rom("R9");
      chk_ram('h6000, "R9");
      do_reset(2);
      sweep_rom("R9");
      chk_ram('h7FFF, "R9");

      // R10: window decode
      chk_sel('h0000, 0, "R10");
      chk_sel('h4FFF, 0, "R10");
      chk_sel('h5FFF, 0, "R10");
      chk_sel('h6000, 1, "R10");
      chk_sel('h7FFF, 1, "R10");
      chk_sel('h8000, 2, "R10");
      chk_sel('hFFFF, 2, "R10");

      // R1 R2 R4..R8: every mode, several patterns and ROM sizes
      for (int ki = 0; ki < 4; ki++) begin
         int k = (ki == 0) ? 2 : (ki == 1) ? 4 : (ki == 2) ? 7 : 0;
         rom_size_log2 = 3'(k);
         m_k = k;
         for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 3; p++) begin
               do_wr('h5100, (p << 2) | (p << 6) | m);           // R1 upper bits ignored
               for (int i = 1; i < 5; i++) begin
                  do_wr('h5113 + i, (p * 73 + i * 41 + 11) & 255); // R2 bit 7 varies
               end
               sweep_rom((k == 7) ? mreq[m] : "R8");
            end
         end
      end

      // R3 R2: work RAM bank, upper data bits dropped
      for (int d = 0; d < 16; d++) begin
         do_wr('h5113, (d * 29 + 3) & 255);
         chk_ram('h6000, "R3");
         chk_ram('h6ABC, "R3");
         chk_ram('h7FFF, "R3");
      end

      // R11: neighbouring addresses and strobe-low writes
      rom_size_log2 = 3'd7;
      m_k = 7;
      do_wr('h5100, 3);
      for (int i = 1; i < 5; i++) do_wr('h5113 + i, i * 9 + 1);
      do_wr('h5113, 5);
      do_wr('h5112, 255);
      do_wr('h5118, 255);
      do_wr('h5101, 0);
      do_wr('h5013, 255);
      do_wr('h4100, 1);
      @(negedge clk);
      wr_addr = 16'h5115;
      wr_data = 8'hFF;
      wr_en = 1'b0;
      @(negedge clk);
      wr_addr = 16'h5100;
      wr_data = 8'h00;
      @(negedge clk);
      sweep_rom("R11");
      chk_ram('h6123, "R11");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule